// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block evaluates a configurable two-level logic function over a set of inputs. Every input bit is split into a true literal and an inverted literal. Each product term ANDs together whichever literals its connection bits select. A fixed OR plane then combines a dedicated group of eight product terms into each output bit.

The connection map is a wide static vector that is set up before the array is used. The array has no clock and no state. Outputs follow any change on the inputs or on the map within the same delta of combinational settling.

Product terms follow fuse-style rules. A term with no connections is high. A term that connects both polarities of the same input is stuck low. These two degenerate cases let a configuration force an output high, or switch off a term it does not need.

Top module: `pal_sop_array`

## Requirements
- R1: Term k = o*8 + t (output o, term t within that output) owns connection bits [k*40 +: 40]. Within a term, bit 2*i selects input i true and bit 2*i+1 selects input i inverted.
- R2: A product term is high exactly when every literal it connects is high.
- R3: A product term with all 40 connection bits clear evaluates high.
- R4: A product term that connects both the true and the inverted literal of any one input evaluates low, whatever the input values are.
- R5: Output o is the OR of its own eight terms. Terms that belong to other outputs have no effect on it.
- R6: The array is purely combinational. Outputs settle to new input or map values with no clock edge.
- R7: A term that connects only the inverted literal of input i follows the complement of that input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_sig | input | 20 | Logic inputs feeding the literal buffers |
| link_map | input | 5120 | Static connection bits, 40 per product term, 128 terms |
| out_sig | output | 16 | OR-plane results, one per output |

## Verification
The bench places one live term at a time against a background of forced-low terms. This shows whether a design gets the empty-term case wrong, since it would then drive an unused output low. It also shows a mis-decoded contradictory term: that term would leak a high whenever one of its literals matched. Terms placed at the edges of the input range and the output index space expose a slipped bit mapping, which would either move an output or read the wrong input. Random maps are compared against a model built from the requirements. These comparisons catch an OR group that is crossed with a neighbour's terms.

// File: rtl/pal_sop_array.sv
module pal_sop_array #(
  parameter int NUM_IN        = 20,
  parameter int NUM_OUT       = 16,
  parameter int TERMS_PER_OUT = 8
) (
  input  logic [NUM_IN-1:0]                          in_sig,
  input  logic [NUM_OUT*TERMS_PER_OUT*2*NUM_IN-1:0]  link_map,
  output logic [NUM_OUT-1:0]                         out_sig
);

  localparam int LIT_W   = 2 * NUM_IN;
  localparam int N_TERMS = NUM_OUT * TERMS_PER_OUT;

  logic [LIT_W-1:0]   lit;
  logic [N_TERMS-1:0] term;

  genvar gi, gk, go;

  generate
    for (gi = 0; gi < NUM_IN; gi++) begin : g_lit
      assign lit[2*gi]   = in_sig[gi];
      assign lit[2*gi+1] = ~in_sig[gi];
    end

    for (gk = 0; gk < N_TERMS; gk++) begin : g_and
      assign term[gk] = &(lit | ~link_map[gk*LIT_W +: LIT_W]);
    end

    for (go = 0; go < NUM_OUT; go++) begin : g_or
      assign out_sig[go] = |term[go*TERMS_PER_OUT +: TERMS_PER_OUT];
    end
  endgenerate

  always_comb begin : chk
    for (int k = 0; k < N_TERMS; k++) begin
      p_empty_term_high_r3: assert (link_map[k*LIT_W +: LIT_W] != '0 || term[k]);
      for (int i = 0; i < NUM_IN; i++) begin
        p_contra_term_low_r4: assert (!(link_map[k*LIT_W+2*i] && link_map[k*LIT_W+2*i+1]) || !term[k]);
        p_true_lit_match_r2: assert (!(term[k] && link_map[k*LIT_W+2*i]) || in_sig[i]);
        p_inv_lit_match_r7: assert (!(term[k] && link_map[k*LIT_W+2*i+1]) || !in_sig[i]);
      end
    end
    for (int o = 0; o < NUM_OUT; o++) begin
      p_out_low_no_term_r5: assert (out_sig[o] || $countones(term[o*TERMS_PER_OUT +: TERMS_PER_OUT]) == 0);
      p_out_high_some_term_r5: assert (!out_sig[o] || $countones(term[o*TERMS_PER_OUT +: TERMS_PER_OUT]) != 0);
    end
  end

endmodule

// File: tb/pal_sop_array_tb.sv
module pal_sop_array_tb_top;
  localparam int NI = 20;
  localparam int NO = 16;
  localparam int NT = 8;
  localparam int LW = 2 * NI;
  localparam int CW = NO * NT * LW;

  // fields: in[60:41], link[40:1], expected[0]
  localparam int NV = 9;
  localparam logic [60:0] VEC [NV] = '{
    {20'h00000, 40'h0000000000, 1'b1},  // R3 empty term
    {20'h00001, 40'h0000000001, 1'b1},  // R2 true literal in0 high
    {20'h00000, 40'h0000000001, 1'b0},  // R2 true literal in0 low
    {20'h00000, 40'h0000000002, 1'b1},  // R7 inverted in0
    {20'h80000, 40'h4000000000, 1'b1},  // R1 top input true
    {20'h80000, 40'h8000000000, 1'b0},  // R7 top input inverted
    {20'hFFFFF, 40'h000000000C, 1'b0},  // R4 contradiction in1
    {20'hFFFFF, 40'h5555555555, 1'b1},  // R2 all true literals
    {20'hFFFFE, 40'h5555555555, 1'b0}   // R2 one literal low
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [NI-1:0] in_sig;
  logic [CW-1:0] link_map;
  logic [NO-1:0] out_sig;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit done = 1'b0;

  pal_sop_array dut_i (.in_sig(in_sig), .link_map(link_map), .out_sig(out_sig));

  function automatic logic [CW-1:0] dead_map();
    logic [CW-1:0] c = '0;
    for (int k = 0; k < NO*NT; k++) begin
      c[k*LW]   = 1'b1;
      c[k*LW+1] = 1'b1;
    end
    return c;
  endfunction

  function automatic logic [NO-1:0] model(input logic [NI-1:0] x, input logic [CW-1:0] c);
    logic [NO-1:0] r = '0;
    for (int o = 0; o < NO; o++) begin
      for (int t = 0; t < NT; t++) begin
        logic ok = 1'b1;
        int k = o*NT + t;
        for (int i = 0; i < NI; i++) begin
          if (c[k*LW+2*i] && !x[i]) ok = 1'b0;
          if (c[k*LW+2*i+1] && x[i]) ok = 1'b0;
        end
        if (ok) r[o] = 1'b1;
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [NO-1:0] act, input logic [NO-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: out=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: out=%h expected=finished", out_sig);
      summary();
      $finish;
    end
  end

  initial begin
    in_sig   = '0;
    link_map = '0;
    @(negedge clk); #1;
    check("R3 blank map all high", out_sig, {NO{1'b1}});

    link_map = dead_map();
    @(negedge clk); #1;
    check("R4 all terms contradictory", out_sig, '0);

    for (int v = 0; v < NV; v++) begin
      for (int p = 0; p < 3; p++) begin
        int o = (v*5 + p*7) % NO;
        int t = (v + p*3) % NT;
        int k = o*NT + t;
        logic [NO-1:0] exp = '0;
        @(negedge clk);
        link_map = dead_map();
        link_map[k*LW +: LW] = VEC[v][40:1];
        in_sig = VEC[v][60:41];
        exp[o] = VEC[v][0];
        #1;
        check($sformatf("R1/R5 vector %0d at out %0d term %0d", v, o, t), out_sig, exp);
      end
    end

    @(negedge clk);
    link_map = dead_map();
    link_map[(15*NT+7)*LW +: LW] = 40'h0000000010;
    in_sig = 20'h00004;
    #1;
    check("R1 last term true in2", out_sig, 16'h8000);
    in_sig = 20'h00000;
    #0.5;
    check("R6 no clock needed", out_sig, 16'h0000);

    for (int n = 0; n < 200; n++) begin
      logic [CW-1:0] c;
      logic [NI-1:0] x;
      @(negedge clk);
      for (int b = 0; b < CW; b++) c[b] = ($urandom % 24) == 0;
      x = NI'($urandom);
      link_map = c;
      in_sig = x;
      #1;
      check("R5 random map", out_sig, model(x, c));
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule